// File: doc/BRIEF.md
# Iterative Shift-In Integer Divider

This block performs unsigned division of a double-width dividend by a single-width divisor over several clock cycles. The dividend arrives as two halves, an upper word and a lower word, each `WIDTH` bits wide. The result is a `2*WIDTH`-bit quotient and a `WIDTH`-bit remainder. A one-cycle `start` pulse loads the operands. `busy` stays high while the division runs, and `done` pulses once when the results on the outputs are valid.

Internally, the block first works on the upper word alone. It holds a partial remainder, a partial quotient and the divisor in state registers, along with a down-counter of lower-word bits not yet consumed. The counter starts at `WIDTH`. Each step unit acts in one of two ways:

- If the partial remainder is below the divisor and bits remain, it shifts in the next lower-word bit, MSB first.
- If the partial remainder is at least the divisor, it aligns the divisor's leading one with the remainder's leading one. It backs off one position if that overshoots, then subtracts.

`STEPS` such units are chained in each clock cycle. Once the counter is zero and the remainder is below the divisor, further steps change nothing. This makes the chain length a free timing knob. A zero divisor is flagged at once through `div_error`, and no iteration takes place.

Top module: `shift_divider`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `div_error` are 0, and `quotient` and `remainder` are 0.
- R2: For a nonzero divisor d and dividend D = {dividend_hi, dividend_lo}, the `done` pulse presents `quotient` = floor(D / d), all 2*WIDTH bits, and `remainder` = D mod d. This holds also when dividend_hi is greater than or equal to d.
- R3: For a nonzero divisor, `busy` is 1 from the first cycle after the start edge up to the cycle before `done`. `done` is a single-cycle pulse, and `busy` is 0 during it.
- R4: A zero divisor gives `done` = 1 and `div_error` = 1 in the first cycle after the start edge. `quotient` and `remainder` are 0 in that cycle, and `busy` never rises.
- R5: A `start` pulse while `busy` is 1 is ignored: the running division completes with the results of its own operands.
- R6: On every error-free completion, `remainder` is strictly less than the divisor.
- R7: With the default parameters (WIDTH = 32, STEPS = 4), `done` arrives no more than WIDTH cycles after the start edge.
- R8: `quotient`, `remainder` and `div_error` keep their values from one completion until the next completion.
- R9: A successful division clears a `div_error` left by an earlier zero-divisor request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request; operands are sampled with it |
| dividend_hi | input | WIDTH | Upper half of the dividend |
| dividend_lo | input | WIDTH | Lower half of the dividend |
| divisor | input | WIDTH | Divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| div_error | output | 1 | Divisor was zero |
| quotient | output | 2*WIDTH | Quotient result |
| remainder | output | WIDTH | Remainder result |

## Verification
The hardest path to reach from the ports is the one where the upper word already meets or exceeds the divisor. In that case, the subtract path with its back-off decision must run repeatedly before any lower-word bit is shifted in, and quotient bits land above position WIDTH. The stimulus drives this directly with an all-ones upper word over a divisor of one, with upper words equal to the divisor, and with random upper words over small divisors. The bench also issues a second start while a division is running, and a zero-divisor request followed by a normal one, so that the error flag is seen both set and cleared.

// File: rtl/shdiv_pkg.sv
package shdiv_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } shdiv_state_e;
endpackage

// File: rtl/shdiv_msb.sv
module shdiv_msb #(
  parameter int W  = 33,
  localparam int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos
);
  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) pos = PW'(i);
    end
  end
endmodule

// File: rtl/shdiv_step.sv
module shdiv_step #(
  parameter int W  = 32,
  localparam int RW = W + 1,
  localparam int QW = 2 * W,
  localparam int CW = $clog2(W + 1),
  localparam int PW = $clog2(RW)
) (
  input  logic [RW-1:0] rem_i,
  input  logic [QW-1:0] quo_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [W-1:0]  dvs_i,
  input  logic [W-1:0]  low_i,
  output logic [RW-1:0] rem_o,
  output logic [QW-1:0] quo_o,
  output logic [CW-1:0] cnt_o
);
  logic [RW-1:0] dvs_ext;
  logic          shift_en;
  logic [CW-1:0] bit_idx;
  logic          in_bit;
  logic [RW-1:0] rem_s;
  logic [QW-1:0] quo_s;
  logic [PW-1:0] msb_rem;
  logic [PW-1:0] msb_dvs;
  logic          sub_en;
  logic [PW-1:0] align;
  logic [RW-1:0] dvs_al;
  logic          overshoot;
  logic [RW-1:0] dvs_use;
  logic [QW-1:0] qbit;

  assign dvs_ext = {1'b0, dvs_i};

  shdiv_msb #(.W(RW)) u_msb_rem (.vec(rem_s),   .pos(msb_rem));
  shdiv_msb #(.W(RW)) u_msb_dvs (.vec(dvs_ext), .pos(msb_dvs));

  // shift-in phase: one lower-word bit when the remainder is short
  always_comb begin
    shift_en = (rem_i < dvs_ext) && (cnt_i != '0);
    bit_idx  = cnt_i - CW'(1);
    in_bit   = low_i[bit_idx];
    if (shift_en) begin
      rem_s = {rem_i[RW-2:0], in_bit};
      quo_s = {quo_i[QW-2:0], 1'b0};
      cnt_o = cnt_i - CW'(1);
    end else begin
      rem_s = rem_i;
      quo_s = quo_i;
      cnt_o = cnt_i;
    end
  end

  // subtract phase: align leading ones, back off once on overshoot
  always_comb begin
    sub_en    = (dvs_i != '0) && (rem_s >= dvs_ext);
    align     = msb_rem - msb_dvs;
    dvs_al    = dvs_ext << align;
    overshoot = dvs_al > rem_s;
    dvs_use   = overshoot ? (dvs_al >> 1) : dvs_al;
    qbit      = (QW'(1) << align) >> overshoot;
    if (sub_en) begin
      rem_o = rem_s - dvs_use;
      quo_o = quo_s + qbit;
    end else begin
      rem_o = rem_s;
      quo_o = quo_s;
    end
  end
endmodule

// File: rtl/shift_divider.sv
module shift_divider
  import shdiv_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int STEPS = 4,
  localparam int RW = WIDTH + 1,
  localparam int QW = 2 * WIDTH,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend_hi,
  input  logic [WIDTH-1:0] dividend_lo,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic             div_error,
  output logic [QW-1:0]    quotient,
  output logic [WIDTH-1:0] remainder
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  shdiv_state_e     state_q, state_d;
  logic [RW-1:0]    rem_q, rem_d;
  logic [QW-1:0]    quo_q, quo_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [WIDTH-1:0] dvs_q, dvs_d;
  logic [WIDTH-1:0] low_q, low_d;
  logic             work_en;
  logic [QW-1:0]    q_out_q, q_out_d;
  logic [WIDTH-1:0] r_out_q, r_out_d;
  logic             err_q, err_d;
  logic             done_q, done_d;
  logic             out_en;

  logic [RW-1:0] rem_c [STEPS+1];
  logic [QW-1:0] quo_c [STEPS+1];
  logic [CW-1:0] cnt_c [STEPS+1];

  assign rem_c[0] = rem_q;
  assign quo_c[0] = quo_q;
  assign cnt_c[0] = cnt_q;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    shdiv_step #(.W(WIDTH)) u_step (
      .rem_i (rem_c[g]),
      .quo_i (quo_c[g]),
      .cnt_i (cnt_c[g]),
      .dvs_i (dvs_q),
      .low_i (low_q),
      .rem_o (rem_c[g+1]),
      .quo_o (quo_c[g+1]),
      .cnt_o (cnt_c[g+1])
    );
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    quo_d   = quo_q;
    cnt_d   = cnt_q;
    dvs_d   = dvs_q;
    low_d   = low_q;
    work_en = 1'b0;
    q_out_d = q_out_q;
    r_out_d = r_out_q;
    err_d   = err_q;
    done_d  = 1'b0;
    out_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (divisor == '0) begin
            out_en  = 1'b1;
            q_out_d = '0;
            r_out_d = '0;
            err_d   = 1'b1;
            done_d  = 1'b1;
          end else begin
            work_en = 1'b1;
            rem_d   = {1'b0, dividend_hi};
            quo_d   = '0;
            cnt_d   = CW'(WIDTH);
            dvs_d   = divisor;
            low_d   = dividend_lo;
            state_d = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        work_en = 1'b1;
        rem_d   = rem_c[STEPS];
        quo_d   = quo_c[STEPS];
        cnt_d   = cnt_c[STEPS];
        if (cnt_c[STEPS] == '0) begin
          out_en  = 1'b1;
          q_out_d = quo_c[STEPS];
          r_out_d = rem_c[STEPS][WIDTH-1:0];
          err_d   = 1'b0;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      rem_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      dvs_q <= '0;
      low_q <= '0;
    end else if (work_en) begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      cnt_q <= cnt_d;
      dvs_q <= dvs_d;
      low_q <= low_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      q_out_q <= '0;
      r_out_q <= '0;
      err_q   <= 1'b0;
    end else if (out_en) begin
      q_out_q <= q_out_d;
      r_out_q <= r_out_d;
      err_q   <= err_d;
    end
  end

  assign busy      = (state_q == ST_RUN);
  assign done      = done_q;
  assign div_error = err_q;
  assign quotient  = q_out_q;
  assign remainder = r_out_q;
endmodule

// File: rtl/shdiv_chk.sv
module shdiv_chk #(
  parameter int WIDTH = 32,
  localparam int QW = 2 * WIDTH,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input logic             clk,
  input logic             rst_s,
  input logic             busy,
  input logic             done,
  input logic             div_error,
  input logic [QW-1:0]    quotient,
  input logic [WIDTH-1:0] remainder,
  input logic [WIDTH-1:0] dvs_q,
  input logic [CW-1:0]    cnt_q
);
  // R3: completion pulse never overlaps a running division
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> !busy);

  // R3: a run ends only through a completion pulse
  assert_end_with_done_R3: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(busy) |-> done);

  // R4: error flag appears only with done and zero results
  assert_err_zero_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (done && div_error) |-> (quotient == '0 && remainder == '0));

  // R4: no iteration on a zero divisor
  assert_err_no_busy_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (done && div_error) |-> !$past(busy));

  // R6: remainder below the divisor on good completions
  assert_rem_below_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (done && !div_error) |-> (remainder < dvs_q));

  // R7: bit counter never climbs during a run
  assert_cnt_down_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && $past(busy)) |-> (cnt_q <= $past(cnt_q)));

  // R8: results change only at a completion
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_s)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_error)));
endmodule

bind shift_divider shdiv_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .busy      (busy),
  .done      (done),
  .div_error (div_error),
  .quotient  (quotient),
  .remainder (remainder),
  .dvs_q     (dvs_q),
  .cnt_q     (cnt_q)
);

// File: tb/shift_divider_tb.sv
`timescale 1ns/1ps
module shift_divider_tb;
  localparam int W  = 32;
  localparam int QW = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [W-1:0]  dividend_hi, dividend_lo, divisor;
  logic          busy, done, div_error;
  logic [QW-1:0] quotient;
  logic [W-1:0]  remainder;

  int n_checks = 0;
  int n_fail   = 0;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;

  shift_divider #(.WIDTH(W), .STEPS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dividend_hi(dividend_hi), .dividend_lo(dividend_lo), .divisor(divisor),
    .busy(busy), .done(done), .div_error(div_error),
    .quotient(quotient), .remainder(remainder)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [QW-1:0] act, input logic [QW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 7);
    lfsr = lfsr ^ (lfsr << 17);
    return lfsr;
  endfunction

  task automatic pulse_start(input logic [W-1:0] hi, input logic [W-1:0] lo,
                             input logic [W-1:0] d);
    @(negedge clk);
    dividend_hi = hi; dividend_lo = lo; divisor = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // waits for done after pulse_start; returns cycles counted from start edge
  task automatic wait_done(output int cyc, input string req);
    cyc = 1;
    while (!done && cyc < 200) begin
      if (!busy) begin
        check(1'b0, req, "busy dropped before done", {63'b0, busy}, 64'd1);
        cyc = 200;
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
  endtask

  task automatic divide_and_check(input logic [W-1:0] hi, input logic [W-1:0] lo,
                                  input logic [W-1:0] d, input string req);
    logic [QW-1:0] dvd, eq, er;
    int cyc;
    dvd = {hi, lo};
    eq  = dvd / {32'b0, d};
    er  = dvd % {32'b0, d};
    pulse_start(hi, lo, d);
    check(busy == 1'b1, "R3", "busy after start", {63'b0, busy}, 64'd1);
    wait_done(cyc, req);
    check(done == 1'b1, "R3", "done arrives", {63'b0, done}, 64'd1);
    check(busy == 1'b0, "R3", "busy low with done", {63'b0, busy}, 64'd0);
    check(cyc <= W, "R7", "latency", QW'(cyc), QW'(W));
    check(quotient == eq, req, "quotient", quotient, eq);
    check({32'b0, remainder} == er, req, "remainder", {32'b0, remainder}, er);
    check(remainder < d, "R6", "remainder below divisor", {32'b0, remainder}, {32'b0, d});
    check(div_error == 1'b0, "R9", "no error", {63'b0, div_error}, 64'd0);
    @(negedge clk);
    check(done == 1'b0, "R3", "done one cycle", {63'b0, done}, 64'd0);
  endtask

  task automatic t_reset();
    check(busy == 0 && done == 0 && div_error == 0, "R1", "reset flags",
          {61'b0, busy, done, div_error}, 64'd0);
    check(quotient == '0 && remainder == '0, "R1", "reset results",
          quotient | {32'b0, remainder}, 64'd0);
  endtask

  task automatic t_corners();
    divide_and_check(32'd0, 32'd100, 32'd7, "R2");
    divide_and_check(32'd0, 32'd5, 32'd9, "R2");
    divide_and_check(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd1, "R2");
    divide_and_check(32'h1234_5678, 32'h9ABC_DEF0, 32'h1234_5678, "R2");
    divide_and_check(32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");
    divide_and_check(32'h8000_0000, 32'h0, 32'd3, "R2");
    divide_and_check(32'd0, 32'hFFFF_FFFF, 32'h8000_0000, "R2");
    divide_and_check(32'd0, 32'd0, 32'd5, "R2");
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      logic [63:0] a, b;
      logic [W-1:0] d;
      a = rnd(); b = rnd();
      case (i % 3)
        0: d = b[31:0] | 32'd1;
        1: d = {24'b0, b[39:32]} | 32'd1;
        default: d = b[31:0] | 32'h8000_0000;
      endcase
      divide_and_check(a[63:32], a[31:0], d, "R2");
    end
  endtask

  task automatic t_zero();
    pulse_start(32'h55, 32'hAA, 32'd0);
    check(done == 1'b1 && div_error == 1'b1, "R4", "zero divisor flags",
          {62'b0, done, div_error}, 64'd3);
    check(quotient == '0 && remainder == '0, "R4", "zero divisor results",
          quotient | {32'b0, remainder}, 64'd0);
    check(busy == 1'b0, "R4", "no busy", {63'b0, busy}, 64'd0);
    @(negedge clk);
    check(div_error == 1'b1 && busy == 1'b0, "R8", "error held",
          {62'b0, div_error, busy}, 64'd2);
    divide_and_check(32'd3, 32'd77, 32'd11, "R9");
  endtask

  task automatic t_busy_start();
    logic [QW-1:0] eq;
    int cyc;
    eq = {32'h0000_0ABC, 32'h1111_2222} / 64'd13;
    pulse_start(32'h0000_0ABC, 32'h1111_2222, 32'd13);
    @(negedge clk);
    dividend_hi = 32'hFFFF; dividend_lo = 32'h1; divisor = 32'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc, "R5");
    check(quotient == eq, "R5", "start while busy ignored", quotient, eq);
    @(negedge clk);
    check(busy == 1'b0, "R5", "no second run", {63'b0, busy}, 64'd0);
  endtask

  task automatic t_hold();
    logic [QW-1:0] q0;
    logic [W-1:0]  r0;
    divide_and_check(32'd9, 32'hDEAD_BEEF, 32'd1000, "R2");
    q0 = quotient; r0 = remainder;
    dividend_hi = 32'h1; dividend_lo = 32'h2; divisor = 32'd3;
    repeat (6) @(negedge clk);
    check(quotient == q0 && remainder == r0, "R8", "results held",
          quotient, q0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0;
    dividend_hi = '0; dividend_lo = '0; divisor = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_corners();
    t_zero();
    t_busy_start();
    t_hold();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule